// File: doc/BRIEF.md
# Daisy-Chain Serial Frame Receiver

This block takes in 24-bit command frames from a serial stream made of a bit clock, a data line and an active-low select. Several copies can share one bus. The clock and data lines go to every copy in parallel. The active-low ready output of each copy drives the select input of the next copy. The first copy therefore takes the first 24 bits of a burst, the second copy takes the next 24, and so on down the chain.

Once a copy has a complete frame, it hands an 8-bit command and a 16-bit data word to a downstream register controller, marked by a one-cycle valid strobe. It then pulls its ready output low, which passes bus ownership to the next copy. A power-control command (code 0x03) can turn off that handoff. No-op frames (code 0x00) still reach the controller, but they leave the receiver's own state unchanged.

The serial inputs are sampled on the core clock. They are expected to be synchronous to it, and the bit clock must be several core cycles slower.

Top module: `chain_frame_rx`

## Requirements
- R1: After reset, readyN is high, frameValid is low, cmdByte and dataWord are zero, and the ready handoff is enabled.
- R2: Data is sampled on the falling edges of sclkIn, MSB first. Of the 24 bits, the first 8 form cmdByte and the last 16 form dataWord. Both appear together with a one-cycle frameValid pulse, one core cycle after the 24th falling edge is sampled.
- R3: Only falling edges that occur while csN is low are counted, starting from the fall of csN. Clock edges while csN is high have no effect on the next frame.
- R4: With the handoff enabled, readyN goes low in the same cycle as frameValid. readyN returns high one cycle after csN is sampled high.
- R5: Once a frame is complete, further bits under the same csN-low window are ignored. No second frameValid is raised, and cmdByte and dataWord keep their values.
- R6: If csN rises before the 24th bit, the partial frame is dropped without a frameValid pulse, and the next frame starts from bit zero.
- R7: A frame with command 0x03 loads the handoff enable from data bit 0. The new value already governs that frame: with bit 0 clear, readyN stays high for that frame and all later frames. With bit 0 set, the handoff is enabled again.
- R8: In a chain of three copies with readyN wired to the next csN, one 72-bit burst under a single select delivers bits 71..48 to the first copy, 47..24 to the second and 23..0 to the third.
- R9: Frames with any command other than 0x03, including the no-op 0x00, are presented but leave the handoff enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial bit clock, sampled by clk |
| csN | input | 1 | Active-low select (previous copy's readyN in a chain) |
| dinIn | input | 1 | Serial data, shared by all copies |
| readyN | output | 1 | Active-low handoff to the next copy's select |
| frameValid | output | 1 | One-cycle strobe for a completed frame |
| cmdByte | output | 8 | Command byte of the last frame |
| dataWord | output | 16 | Data word of the last frame |

## Verification
The bench targets slot boundaries in a three-copy chain. A copy that miscounts by one bit shifts every downstream frame, so all three scoreboards would mismatch. It also drives overrun bits past a finished frame and aborted partial frames. A receiver that keeps shifting after its slot would raise a second frame, and one that keeps a stale count would deliver a misaligned word. The enable bit is toggled through the power-control command and then probed with a no-op. A design that applies the setting one frame late, or that lets other commands clear it, would show the wrong readyN level right after the frame.

// File: rtl/chain_rx_pkg.sv
package chain_rx_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic shiftEn;   // take dinIn into the shift register this cycle
    logic lastBit;   // this shift completes the frame
    logic csIdle;    // select is deasserted
  } rxStrobe_t;
endpackage

// File: rtl/chain_rx_ctrl.sv
module chain_rx_ctrl
  import chain_rx_pkg::*;
#(
  parameter int FRAME_BITS = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclkIn,
  input  logic      csN,
  output rxStrobe_t strobe
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {ST_ARMED, ST_SHIFT, ST_HELD} rxState_t;

  rxState_t      state;
  logic          sclkPrev;
  logic [CW-1:0] bitCnt;
  logic          sclkFall;

  assign sclkFall = sclkPrev && !sclkIn;

  always_comb begin
    strobe.csIdle  = csN;
    strobe.shiftEn = !csN && sclkFall && (state != ST_HELD);
    strobe.lastBit = strobe.shiftEn && (bitCnt == CW'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      state    <= ST_ARMED;
    end else begin
      sclkPrev <= sclkIn;
      if (csN) begin
        bitCnt <= '0;
        state  <= ST_ARMED;
      end else if (strobe.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
        state  <= strobe.lastBit ? ST_HELD : ST_SHIFT;
      end
    end
  end

  // R6: a deasserted select always restarts the bit count
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> (bitCnt == '0));
  // R5: the count never runs past one frame
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CW'(FRAME_BITS));
  // R3: no shifting while deselected
  p_no_shift_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> $stable(bitCnt) || bitCnt == '0);
endmodule

// File: rtl/chain_rx_datapath.sv
module chain_rx_datapath
  import chain_rx_pkg::*;
#(
  parameter int          FRAME_BITS = 24,
  parameter int          CMD_BITS   = 8,
  parameter logic [7:0]  PWR_CMD    = 8'h03,
  parameter int          RDY_EN_BIT = 0,
  localparam int         DATA_BITS  = FRAME_BITS - CMD_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dinIn,
  input  rxStrobe_t            strobe,
  output logic [CMD_BITS-1:0]  cmdByte,
  output logic [DATA_BITS-1:0] dataWord,
  output logic                 frameValid,
  output logic                 readyN
);
  logic [FRAME_BITS-2:0]  shiftReg;
  logic [FRAME_BITS-1:0]  frameNext;
  logic [CMD_BITS-1:0]    cmdNext;
  logic [DATA_BITS-1:0]   dataNext;
  logic                   readyEn;
  logic                   enNext;

  always_comb begin
    frameNext = {shiftReg, dinIn};
    cmdNext   = frameNext[FRAME_BITS-1 -: CMD_BITS];
    dataNext  = frameNext[DATA_BITS-1:0];
    enNext    = (cmdNext == CMD_BITS'(PWR_CMD)) ? dataNext[RDY_EN_BIT] : readyEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      cmdByte    <= '0;
      dataWord   <= '0;
      frameValid <= 1'b0;
      readyEn    <= 1'b1;
      readyN     <= 1'b1;
    end else begin
      frameValid <= 1'b0;
      if (strobe.shiftEn) shiftReg <= frameNext[FRAME_BITS-2:0];
      if (strobe.lastBit) begin
        cmdByte    <= cmdNext;
        dataWord   <= dataNext;
        frameValid <= 1'b1;
        readyEn    <= enNext;
        if (enNext) readyN <= 1'b0;
      end
      if (strobe.csIdle) readyN <= 1'b1;
    end
  end

  // R4: handoff released the cycle after select goes high
  p_ready_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.csIdle |=> readyN);
  // R4: handoff only ever starts alongside a completed frame
  p_ready_with_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readyN) |-> frameValid);
  // R2: the valid strobe lasts one cycle
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |=> !frameValid);
  // R7: a disabled handoff keeps readyN high
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !readyEn |-> readyN);
endmodule

// File: rtl/chain_frame_rx.sv
module chain_frame_rx
  import chain_rx_pkg::*;
#(
  parameter int          FRAME_BITS = 24,
  parameter int          CMD_BITS   = 8,
  parameter logic [7:0]  PWR_CMD    = 8'h03,
  parameter int          RDY_EN_BIT = 0,
  localparam int         DATA_BITS  = FRAME_BITS - CMD_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclkIn,
  input  logic                 csN,
  input  logic                 dinIn,
  output logic                 readyN,
  output logic                 frameValid,
  output logic [CMD_BITS-1:0]  cmdByte,
  output logic [DATA_BITS-1:0] dataWord
);
  rxStrobe_t strobe;

  chain_rx_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclkIn (sclkIn),
    .csN    (csN),
    .strobe (strobe)
  );

  chain_rx_datapath #(
    .FRAME_BITS (FRAME_BITS),
    .CMD_BITS   (CMD_BITS),
    .PWR_CMD    (PWR_CMD),
    .RDY_EN_BIT (RDY_EN_BIT)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dinIn      (dinIn),
    .strobe     (strobe),
    .cmdByte    (cmdByte),
    .dataWord   (dataWord),
    .frameValid (frameValid),
    .readyN     (readyN)
  );
endmodule

// File: tb/chain_frame_rx_tb_top.sv
`timescale 1ns/1ps
module chain_frame_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csHost = 1'b1;
  logic din = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rdy0, rdy1, rdy2;
  logic        fv0, fv1, fv2;
  logic [7:0]  cmd0, cmd1, cmd2;
  logic [15:0] dat0, dat1, dat2;

  chain_frame_rx dut_i (.clk(clk), .rst_n(rst_n), .sclkIn(sclk), .csN(csHost), .dinIn(din),
    .readyN(rdy0), .frameValid(fv0), .cmdByte(cmd0), .dataWord(dat0));
  chain_frame_rx link_b_i (.clk(clk), .rst_n(rst_n), .sclkIn(sclk), .csN(rdy0), .dinIn(din),
    .readyN(rdy1), .frameValid(fv1), .cmdByte(cmd1), .dataWord(dat1));
  chain_frame_rx link_c_i (.clk(clk), .rst_n(rst_n), .sclkIn(sclk), .csN(rdy1), .dinIn(din),
    .readyN(rdy2), .frameValid(fv2), .cmdByte(cmd2), .dataWord(dat2));

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [23:0] q0[$], q1[$], q2[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare as frames appear
  task automatic onFrame(int dev, logic [7:0] c, logic [15:0] d);
    logic [23:0] e;
    int sz;
    sz = (dev == 0) ? q0.size() : (dev == 1) ? q1.size() : q2.size();
    if (sz == 0) begin
      chk("R5", 32'(dev), 32'hFF, "unexpected frame on device");
    end else begin
      if (dev == 0) e = q0.pop_front();
      else if (dev == 1) e = q1.pop_front();
      else e = q2.pop_front();
      chk("R2/R8", {8'h0, c, d}, {8'h0, e}, $sformatf("frame on device %0d", dev));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (fv0) onFrame(0, cmd0, dat0);
      if (fv1) onFrame(1, cmd1, dat1);
      if (fv2) onFrame(2, cmd2, dat2);
    end
  end

  task automatic waitClk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBits(logic [23:0] w, int n);
    for (int i = 23; i > 23 - n; i--) begin
      din = w[i];
      sclk = 1'b1;
      waitClk(3);
      sclk = 1'b0;
      waitClk(3);
    end
  endtask

  // driver: shift a frame and record what device dev should receive
  task automatic sendFrame(int dev, logic [23:0] w);
    if (dev == 0) q0.push_back(w);
    else if (dev == 1) q1.push_back(w);
    else if (dev == 2) q2.push_back(w);
    sendBits(w, 24);
  endtask

  task automatic selOn();
    csHost = 1'b0;
    waitClk(2);
  endtask

  task automatic selOff();
    csHost = 1'b1;
    waitClk(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    rst_n = 1'b1;
    waitClk(2);
    // R1 reset state
    chk("R1", {29'h0, rdy0, rdy1, rdy2}, 32'h7, "readyN after reset");
    chk("R1", {29'h0, fv0, fv1, fv2}, 32'h0, "frameValid after reset");
    chk("R1", {8'h0, cmd0, dat0}, 32'h0, "outputs after reset");

    // R3: clocks while deselected are ignored
    sendBits(24'hFFFFFF, 5);
    // single frame to first device, R2/R4
    selOn();
    sendFrame(0, 24'hA5_1234);
    chk("R4", {31'h0, rdy0}, 32'h0, "readyN low after own frame");
    chk("R4", {31'h0, rdy1}, 32'h1, "next device idle without bits");
    selOff();
    chk("R4", {29'h0, rdy0, rdy1, rdy2}, 32'h7, "readyN released after select rise");

    // R8 chained 72-bit burst
    selOn();
    sendFrame(0, 24'h11_AAAA);
    sendFrame(1, 24'h22_5555);
    sendFrame(2, 24'h33_0F0F);
    chk("R8", {29'h0, rdy0, rdy1, rdy2}, 32'h0, "all handed off after burst");
    selOff();

    // R6 partial frame dropped
    selOn();
    sendBits(24'hFFFFFF, 10);
    selOff();
    chk("R6", {31'h0, rdy0}, 32'h1, "no handoff after partial frame");
    selOn();
    sendFrame(0, 24'h4C_8001);
    selOff();

    // R5 overrun bits after last device ignored
    selOn();
    sendFrame(0, 24'h01_0101);
    sendFrame(1, 24'h02_0202);
    sendFrame(2, 24'h7E_BEEF);
    sendBits(24'h123456, 24);
    chk("R5", {8'h0, cmd2, dat2}, 32'h007EBEEF, "last device holds frame after overrun");
    selOff();

    // R7 disable handoff
    selOn();
    sendFrame(0, 24'h03_0000);
    chk("R7", {31'h0, rdy0}, 32'h1, "readyN held high when disabled");
    sendBits(24'h99_9999, 24);
    chk("R7", {30'h0, rdy1, rdy2}, 32'h3, "no downstream select when disabled");
    selOff();
    // R9 no-op keeps it disabled
    selOn();
    sendFrame(0, 24'h00_FFFF);
    chk("R9", {31'h0, rdy0}, 32'h1, "no-op leaves handoff disabled");
    selOff();
    // R7 re-enable takes effect in the same frame
    selOn();
    sendFrame(0, 24'h03_0001);
    chk("R7", {31'h0, rdy0}, 32'h0, "handoff re-enabled at once");
    selOff();

    // R9 no-op on middle device keeps its handoff
    selOn();
    sendFrame(0, 24'h05_1234);
    sendFrame(1, 24'h00_0000);
    chk("R9", {30'h0, rdy1, rdy2}, 32'h1, "middle device hands off after no-op");
    selOff();

    waitClk(4);
    chk("R8", 32'(q0.size() + q1.size() + q2.size()), 32'h0, "all expected frames delivered");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule